// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block turns the interrupt sources of a 16550-style serial port into one identification byte and one interrupt request line. It holds the 4-bit interrupt enable value and the "transmit holding empty" pending flag. Each clock it chooses the highest-priority source that is both active and enabled, and registers the result.

The surrounding UART supplies the raw conditions:
- the line error bits and data-ready,
- the character-timeout pending flag,
- the receive FIFO fill count and trigger-level selection,
- the modem status delta bits,
- the FIFO-enable state.

It also supplies strobes for a write to the enable register, a read of the identification register, a write to the transmit holding register, and the moment the transmitter drains.

The identification byte is ready to be returned on a register read. The request line goes to the interrupt controller.

Top module: `uirq_resolver`

## Requirements
- R1: Sources are ranked, highest first: line status, character timeout, receive data, transmit holding empty, modem status. When several are active, only the highest is reported.
- R2: `iid[3:0]` takes these codes:
  - 0x6 for line status
  - 0xC for character timeout
  - 0x4 for receive data
  - 0x2 for transmit holding empty
  - 0x0 for modem status
  - 0x1 when nothing is pending.
- R3: A line status interrupt needs enable bit 2 and at least one bit of `lsr_err` set. The bits of `lsr_err` are: 0 overrun, 1 parity, 2 framing, 3 break.
- R4: The character-timeout source is gated by enable bit 0, the receive-data enable. It has no enable of its own.
- R5: Receive data needs enable bit 0 and `data_rdy`.
  - With FIFOs disabled, nothing more is needed.
  - With FIFOs enabled, `rx_count` must also be at or above the trigger level. `trig_sel` 0, 1, 2 and 3 select 1, DEPTH/4, DEPTH/2 and DEPTH-2 entries (1, 4, 8, 14 at DEPTH=16).
- R6: `iid[7:6]` reads 2'b11 while `fifo_en` is high and 2'b00 otherwise. `iid[5:4]` is always 0.
- R7: A read strobe on the identification register while `iid[3:0]` is 0x2 clears the transmit-empty pending flag. This applies unless the same cycle also has a set event.
- R8: An enable write keeps only `ien_wdata[3:0]`, which reads back on `ien_q`. If `thr_empty` is high during the write, the transmit-empty pending flag is set.
- R9: `irq` is high exactly when `iid[3:0]` is not 0x1.
- R10: `iid` and `irq` reflect the inputs and strobes of cycle k after the clock edge that ends cycle k. This is a single register stage.
- R11: After synchronous reset (`rst_n` low), `iid` is 0x01, `irq` is 0 and `ien_q` is 0.
- R12: A `tx_empty_evt` pulse sets the transmit-empty pending flag. A `thr_wr` pulse clears it and takes precedence over every set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_we | input | 1 | Write strobe for the enable register |
| ien_wdata | input | 8 | Enable write data (low 4 bits kept) |
| iid_rd | input | 1 | Read strobe of the identification register |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| tx_empty_evt | input | 1 | Transmit holding register just became empty |
| thr_empty | input | 1 | Transmit holding register currently empty |
| lsr_err | input | 4 | Overrun, parity, framing, break status |
| data_rdy | input | 1 | Receive data ready |
| rx_tmo_pend | input | 1 | Character timeout pending |
| rx_count | input | CNT_W | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger level select |
| fifo_en | input | 1 | FIFOs enabled |
| msr_delta | input | 4 | Modem status change bits |
| ien_q | output | 4 | Current enable register value |
| iid | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block at the default FIFO_DEPTH of 16, which makes CNT_W 5. With these values each of the four trigger levels (1, 4, 8, 14) can be reached, and so can a full FIFO count of 16. Directed phases walk each trigger level at count one below and at the level itself. A long random phase mixes every source with the strobes, so the read-clear, set and write-clear collisions occur many times against the behavioural model.

// File: rtl/uirq_pkg.sv
// Package: shared codes and trigger-level mapping for the interrupt resolver.
// Assumes the receive FIFO depth is at least 4.
package uirq_pkg;
    localparam logic [3:0] CODE_LINE = 4'h6;
    localparam logic [3:0] CODE_TMO  = 4'hC;
    localparam logic [3:0] CODE_RXD  = 4'h4;
    localparam logic [3:0] CODE_THRE = 4'h2;
    localparam logic [3:0] CODE_MDM  = 4'h0;
    localparam logic [3:0] CODE_NONE = 4'h1;

    // Enable register bit positions.
    localparam int EN_RXD  = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;

    // Maps a trigger select to a fill level for a FIFO of the given depth.
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction
endpackage

// File: rtl/uirq_ien_reg.sv
// Module: holds the 4-bit interrupt enable value.
// Assumes a write strobe lasts one cycle; upper data bits are discarded.
module uirq_ien_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [3:0] ien_d,
    output logic [3:0] ien_q
);
    // Next value: new low nibble on a write, else hold.
    always_comb ien_d = we ? wdata[3:0] : ien_q;

    // Register the enable value.
    always_ff @(posedge clk) begin
        if (!rst_n) ien_q <= 4'h0;
        else        ien_q <= ien_d;
    end
endmodule

// File: rtl/uirq_thre_flag.sv
// Module: transmit-holding-empty pending flag.
// A holding write clears it above all else; set events beat the read clear.
module uirq_thre_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic set_evt,
    input  logic rd_clr,
    output logic pend_d,
    output logic pend_q
);
    // Next state with clear/set precedence.
    always_comb begin
        if (thr_wr)       pend_d = 1'b0;
        else if (set_evt) pend_d = 1'b1;
        else if (rd_clr)  pend_d = 1'b0;
        else              pend_d = pend_q;
    end

    // Hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/uirq_prio.sv
// Module: fixed-priority selection of the interrupt identification code.
// Purely combinational; the caller registers the result.
module uirq_prio #(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ien,
    input  logic [3:0]       lsr_err,
    input  logic             data_rdy,
    input  logic             tmo_pend,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic             fifo_en,
    input  logic             thre_pend,
    input  logic [3:0]       msr_delta,
    output logic [3:0]       code
);
    import uirq_pkg::*;

    logic rx_level_ok;

    // Receive-data qualification: trigger level only matters in FIFO mode.
    always_comb rx_level_ok = !fifo_en || (rx_count >= trig_lvl);

    // Priority chain, highest source first.
    always_comb begin
        if (ien[EN_LINE] && (|lsr_err))                     code = CODE_LINE;
        else if (ien[EN_RXD] && tmo_pend)                   code = CODE_TMO;
        else if (ien[EN_RXD] && data_rdy && rx_level_ok)    code = CODE_RXD;
        else if (ien[EN_THRE] && thre_pend)                 code = CODE_THRE;
        else if (ien[EN_MDM] && (|msr_delta))               code = CODE_MDM;
        else                                                code = CODE_NONE;
    end
endmodule

// File: rtl/uirq_resolver.sv
// Module: top of the interrupt resolver. Combines the enable register,
// the transmit-empty flag and the priority chain, and registers the
// identification byte and request line (one stage of latency).
// Assumes all strobes are single-cycle and synchronous to clk.
module uirq_resolver #(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_we,
    input  logic [7:0]       ien_wdata,
    input  logic             iid_rd,
    input  logic             thr_wr,
    input  logic             tx_empty_evt,
    input  logic             thr_empty,
    input  logic [3:0]       lsr_err,
    input  logic             data_rdy,
    input  logic             rx_tmo_pend,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_en,
    input  logic [3:0]       msr_delta,
    output logic [3:0]       ien_q,
    output logic [7:0]       iid,
    output logic             irq
);
    import uirq_pkg::*;

    logic [3:0]       ien_d;
    logic             pend_d, pend_q;
    logic [3:0]       code;
    logic [CNT_W-1:0] trig_lvl;
    logic             rd_clr, set_evt;

    uirq_ien_reg u_ien (
        .clk(clk), .rst_n(rst_n), .we(ien_we), .wdata(ien_wdata),
        .ien_d(ien_d), .ien_q(ien_q)
    );

    // Flag events: drain or enable write while empty sets; read of a reported THRE clears.
    always_comb begin
        set_evt = tx_empty_evt || (ien_we && thr_empty);
        rd_clr  = iid_rd && (iid[3:0] == CODE_THRE);
    end

    uirq_thre_flag u_flag (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .set_evt(set_evt),
        .rd_clr(rd_clr), .pend_d(pend_d), .pend_q(pend_q)
    );

    // Trigger level lookup for the selected threshold.
    always_comb trig_lvl = CNT_W'(trig_level(trig_sel, FIFO_DEPTH));

    uirq_prio #(.CNT_W(CNT_W)) u_prio (
        .ien(ien_d), .lsr_err(lsr_err), .data_rdy(data_rdy),
        .tmo_pend(rx_tmo_pend), .rx_count(rx_count), .trig_lvl(trig_lvl),
        .fifo_en(fifo_en), .thre_pend(pend_d), .msr_delta(msr_delta),
        .code(code)
    );

    // Output register stage for the identification byte and request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iid <= {4'h0, CODE_NONE};
            irq <= 1'b0;
        end else begin
            iid <= {{2{fifo_en}}, 2'b00, code};
            irq <= (code != CODE_NONE);
        end
    end

    // R3 / R1: an enabled line error always wins the next cycle.
    a_r3_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q[EN_LINE] && (|lsr_err) && !ien_we) |=> (iid[3:0] == CODE_LINE));

    // R4: with receive-data disabled neither timeout nor data can be reported.
    a_r4_tmo_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_q[EN_RXD] && !ien_we) |=> (iid[3:0] != CODE_TMO && iid[3:0] != CODE_RXD));

    // R6: top bits follow the FIFO-enable state.
    a_r6_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (iid[7:6] == {2{$past(fifo_en)}} && iid[5:4] == 2'b00));

    // R7: reading a reported THRE without a set event removes it.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_rd && iid[3:0] == CODE_THRE && !tx_empty_evt && !ien_we) |=> (iid[3:0] != CODE_THRE));

    // R8: only the low nibble of an enable write is kept.
    a_r8_ien_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        ien_we |=> (ien_q == $past(ien_wdata[3:0])));

    // R9: request line agrees with the identification code.
    a_r9_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iid[3:0] != CODE_NONE));

    // R12: a holding write leaves no THRE report.
    a_r12_thr_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (iid[3:0] != CODE_THRE));
endmodule

// File: tb/uirq_resolver_tb_top.sv
// Bench: behavioural reference model updated each rising edge and compared
// with the outputs on every falling edge.
module uirq_resolver_tb_top;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0;
    logic ien_we = 0, iid_rd = 0, thr_wr = 0, tx_empty_evt = 0, thr_empty = 0;
    logic [7:0] ien_wdata = 0;
    logic [3:0] lsr_err = 0, msr_delta = 0;
    logic data_rdy = 0, rx_tmo_pend = 0, fifo_en = 0;
    logic [CW-1:0] rx_count = 0;
    logic [1:0] trig_sel = 0;
    logic [3:0] ien_q;
    logic [7:0] iid;
    logic irq;

    int errors = 0, checks = 0;
    string phase = "R11";

    // Model state.
    int m_ien = 0, m_pend = 0, m_iid = 1, m_irq = 0;

    always #4 clk = ~clk;

    uirq_resolver #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .iid_rd(iid_rd), .thr_wr(thr_wr), .tx_empty_evt(tx_empty_evt),
        .thr_empty(thr_empty), .lsr_err(lsr_err), .data_rdy(data_rdy),
        .rx_tmo_pend(rx_tmo_pend), .rx_count(rx_count), .trig_sel(trig_sel),
        .fifo_en(fifo_en), .msr_delta(msr_delta),
        .ien_q(ien_q), .iid(iid), .irq(irq)
    );

    function automatic int lvl(int sel);
        int t [4] = '{1, 4, 8, 14};
        return t[sel];
    endfunction

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        int code;
        if (!rst_n) begin
            m_ien = 0; m_pend = 0; m_iid = 1; m_irq = 0;
        end else begin
            if (ien_we) m_ien = ien_wdata & 15;
            if (thr_wr) m_pend = 0;
            else if (tx_empty_evt || (ien_we && thr_empty)) m_pend = 1;
            else if (iid_rd && (m_iid & 15) == 2) m_pend = 0;
            if (m_ien[2] && lsr_err != 0) code = 6;
            else if (m_ien[0] && rx_tmo_pend) code = 12;
            else if (m_ien[0] && data_rdy && (!fifo_en || rx_count >= lvl(trig_sel))) code = 4;
            else if (m_ien[1] && m_pend != 0) code = 2;
            else if (m_ien[3] && msr_delta != 0) code = 0;
            else code = 1;
            m_iid = code + (fifo_en ? 192 : 0);
            m_irq = (code != 1);
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        checks++;
        if (iid !== 8'(m_iid) || irq !== 1'(m_irq) || ien_q !== 4'(m_ien)) begin
            errors++;
            $display("FAIL %s: iid=%h irq=%b ien=%h expected iid=%h irq=%b ien=%h",
                     phase, iid, irq, ien_q, 8'(m_iid), 1'(m_irq), 4'(m_ien));
        end
    end

    task automatic chk(input string req, input logic [7:0] exp_iid);
        checks++;
        if (iid !== exp_iid || irq !== (exp_iid[3:0] != 4'h1)) begin
            errors++;
            $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b",
                     req, iid, irq, exp_iid, exp_iid[3:0] != 4'h1);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr_ien(input logic [7:0] v);
        ien_we = 1; ien_wdata = v; step(); ien_we = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        phase = "R11"; chk("R11", 8'h01);
        checks++;
        if (ien_q !== 4'h0) begin errors++; $display("FAIL R11: ien=%h expected 0", ien_q); end
        rst_n = 1; step();

        // R8: nibble kept, THRE pending set while empty.
        phase = "R8"; thr_empty = 1; wr_ien(8'hF2); step();
        checks++;
        if (ien_q !== 4'h2) begin errors++; $display("FAIL R8: ien=%h expected 2", ien_q); end
        chk("R8", 8'h02);
        // R7: read while THRE reported clears it.
        phase = "R7"; iid_rd = 1; step(); iid_rd = 0; chk("R7", 8'h01);
        // R12: drain event sets, holding write clears.
        phase = "R12"; tx_empty_evt = 1; step(); tx_empty_evt = 0; chk("R12", 8'h02);
        thr_wr = 1; tx_empty_evt = 1; step(); thr_wr = 0; tx_empty_evt = 0; chk("R12", 8'h01);

        // R1 / R2 / R9: stack all sources then peel them off.
        phase = "R1"; thr_empty = 0; wr_ien(8'h0F);
        tx_empty_evt = 1; lsr_err = 4'h1; rx_tmo_pend = 1; data_rdy = 1; msr_delta = 4'h8;
        step(); tx_empty_evt = 0; step(); chk("R1", 8'h06);
        lsr_err = 0; step(); chk("R2", 8'h0C);
        rx_tmo_pend = 0; step(); chk("R2", 8'h04);
        data_rdy = 0; step(); chk("R2", 8'h02);
        thr_wr = 1; step(); thr_wr = 0; chk("R9", 8'h00);
        msr_delta = 0; step(); chk("R9", 8'h01);

        // R3: each error bit alone, and without its enable.
        phase = "R3";
        for (int b = 0; b < 4; b++) begin
            lsr_err = 4'(1 << b); step(); chk("R3", 8'h06);
        end
        wr_ien(8'h0B); step(); chk("R3", 8'h01); lsr_err = 0;

        // R4: timeout gated by receive-data enable.
        phase = "R4"; rx_tmo_pend = 1; wr_ien(8'h0E); step(); chk("R4", 8'h01);
        wr_ien(8'h01); step(); chk("R4", 8'h0C); rx_tmo_pend = 0;

        // R5 / R6: trigger levels in FIFO mode, data alone in non-FIFO mode.
        phase = "R5"; data_rdy = 1; fifo_en = 1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            rx_count = CW'(lvl(s) - 1); step(); step(); chk("R5", 8'hC1);
            rx_count = CW'(lvl(s)); step(); chk("R5", 8'hC4);
        end
        rx_count = CW'(DEPTH); step(); chk("R6", 8'hC4);
        phase = "R6"; fifo_en = 0; rx_count = 0; step(); chk("R6", 8'h04);
        data_rdy = 0; step(); chk("R6", 8'h01);

        // R10: one-stage latency on a single-cycle source.
        phase = "R10"; msr_delta = 4'h2; wr_ien(8'h08); chk("R10", 8'h00);
        msr_delta = 0; step(); chk("R10", 8'h01);

        // Random mix of sources and strobes.
        phase = "R1 random";
        for (int i = 0; i < 3000; i++) begin
            ien_we = ($urandom_range(0, 7) == 0); ien_wdata = 8'($urandom);
            iid_rd = ($urandom_range(0, 2) == 0); thr_wr = ($urandom_range(0, 9) == 0);
            tx_empty_evt = ($urandom_range(0, 5) == 0); thr_empty = 1'($urandom);
            lsr_err = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
            data_rdy = 1'($urandom); rx_tmo_pend = ($urandom_range(0, 4) == 0);
            rx_count = CW'($urandom_range(0, DEPTH)); trig_sel = 2'($urandom);
            fifo_en = 1'($urandom); msr_delta = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            step();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule